// File: doc/BRIEF.md
# Privilege-Selected Endianness Data Swapper

This block sits on the data path between a processor's load/store unit and a memory port that is always little-endian. Each access arrives as one stream beat carrying an access kind (instruction fetch, load or store), a size code, the privilege level the hart is running at, and the data. The block works out the privilege that governs the access and reads that level's endianness control bit. When that bit asks for big-endian order, it reverses the bytes of the data across the access width. The result leaves on an output stream in the same cycle.

The block also holds the few status-word fields that drive this choice: a machine, a supervisor and a user big-endian bit, the memory-privilege override bit and the previous-privilege field. Software writes the full status word through a plain write port. The block keeps only its own fields, legalizes them against the privilege modes that are built in, and returns them on a read-back word. The stream has no storage. A beat is transferred when `req_valid` and `rsp_ready` are both high. `req_ready` follows `rsp_ready`, so back-pressure from the consumer reaches the producer in the same cycle. A producer that holds its beat while stalled sees the same result on `rsp_data` for as long as it waits.

Top module: `endian_swapper_top`

## Requirements
- R1: The effective privilege of an access is its request privilege, except for a load or store (kind not 0) issued at machine level (code 3) while the override bit is 1, which takes the stored previous-privilege field instead. Privilege codes are 0 user, 1 supervisor, 3 machine, and code 2 is treated as machine. The control bit used is the one for the effective privilege.
- R2: An instruction fetch (kind code 0) is never reversed, and `rsp_swapped` stays 0 for it.
- R3: For a load (kind 1), when the selected bit is 1, the bytes of the access are reversed and `rsp_swapped` is 1. When the selected bit is 0, the data passes through unchanged.
- R4: A store (kind 2, and the spare code 3) follows the same rule as a load before the data goes to memory.
- R5: Size code s means an access of 2^s bytes. Byte i of an n-byte access swaps with byte n-1-i, and bytes above the access width pass through unchanged. A one-byte access is never altered.
- R6: After reset the three endianness bits and the override bit are 0, and the previous-privilege field holds machine (3).
- R7: The machine big-endian bit, at status bit 37, takes any written value.
- R8: The supervisor big-endian bit, at status bit 36, takes a written value only when the supervisor mode is built in (HAS_S=1). Otherwise it reads 0.
- R9: The user big-endian bit, at status bit 6, takes a written value only when the user mode is built in (HAS_U=1). Otherwise it reads 0.
- R10: The override bit (status bit 17) reads 0 when there is no user mode. The previous-privilege field (bits 12:11) keeps its old value when the written code is reserved or names a mode that is not built in.
- R11: A status write takes effect on its clock edge and governs accesses from the next cycle on. Without a write, all held fields stay unchanged.
- R12: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in every cycle. The result is combinational from the beat.
- R13: `csr_rdata` shows the held fields at their status-word positions, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Status-word write strobe |
| csr_wdata | input | STATUS_W | Status word being written |
| csr_rdata | output | STATUS_W | Legalized fields held by the block |
| req_valid | input | 1 | Access beat present |
| req_ready | output | 1 | Beat accepted when high with req_valid |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as store |
| req_size | input | SIZE_W | Access size code, 2^code bytes |
| req_priv | input | 2 | Current privilege level |
| req_data | input | 8*DATA_BYTES | Data from memory (load, fetch) or core (store) |
| rsp_valid | output | 1 | Result beat present |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_data | output | 8*DATA_BYTES | Data in the order the destination expects |
| rsp_swapped | output | 1 | High when the bytes were reversed |

## Verification
The bench builds two copies of the block, both with 8-byte data. One has every privilege mode built in. The other has only machine mode (HAS_S=0, HAS_U=0). On the full copy the bench sweeps all eight endianness-bit combinations against both override settings and every legal previous privilege. For each setting it tries every request privilege (including the reserved code), every access kind and every size, so each path through the privilege override and each reversal width is reached. The machine-only copy brings the forced-zero bits and the retained previous-privilege field within reach.

// File: rtl/endian_pkg.sv
package endian_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_SPARE = 2'd3
  } acc_kind_e;

  // Field positions inside the status word; neighbouring logic decodes these.
  localparam int unsigned BIG_M_POS    = 37;
  localparam int unsigned BIG_S_POS    = 36;
  localparam int unsigned BIG_U_POS    = 6;
  localparam int unsigned OVR_POS      = 17;
  localparam int unsigned PREV_LO_POS  = 11;
  localparam int unsigned MIN_STATUS_W = 38;

endpackage

// File: rtl/endian_ctrl_regs.sv
module endian_ctrl_regs
  import endian_pkg::*;
#(
  parameter int unsigned STATUS_W = 64,
  parameter bit          HAS_S    = 1'b1,
  parameter bit          HAS_U    = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [STATUS_W-1:0] wr_word,
  output logic                big_m,
  output logic                big_s,
  output logic                big_u,
  output logic                ovr,
  output priv_e               prev_priv,
  output logic [STATUS_W-1:0] rd_word
);

  logic  big_m_q;
  priv_e prev_q;
  priv_e prev_wr;
  logic  unused_wr_bits;

  assign prev_wr        = priv_e'(wr_word[PREV_LO_POS +: 2]);
  assign unused_wr_bits = ^wr_word;

  // Previous-privilege legalization: keep the old code for illegal values.
  function automatic priv_e legal_prev(priv_e cand, priv_e old);
    priv_e r;
    unique case (cand)
      PRIV_M:  r = cand;
      PRIV_S:  r = HAS_S ? cand : old;
      PRIV_U:  r = HAS_U ? cand : old;
      default: r = old;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_m_q <= 1'b0;
      prev_q  <= PRIV_M;
    end else if (wr_en) begin
      big_m_q <= wr_word[BIG_M_POS];
      prev_q  <= legal_prev(prev_wr, prev_q);
    end
  end

  generate
    if (HAS_S) begin : g_sup
      logic big_s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     big_s_q <= 1'b0;
        else if (wr_en) big_s_q <= wr_word[BIG_S_POS];
      end
      assign big_s = big_s_q;
    end else begin : g_no_sup
      assign big_s = 1'b0;
    end

    if (HAS_U) begin : g_usr
      logic big_u_q;
      logic ovr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          big_u_q <= 1'b0;
          ovr_q   <= 1'b0;
        end else if (wr_en) begin
          big_u_q <= wr_word[BIG_U_POS];
          ovr_q   <= wr_word[OVR_POS];
        end
      end
      assign big_u = big_u_q;
      assign ovr   = ovr_q;
    end else begin : g_no_usr
      assign big_u = 1'b0;
      assign ovr   = 1'b0;
    end
  endgenerate

  assign big_m     = big_m_q;
  assign prev_priv = prev_q;

  always_comb begin
    rd_word                    = '0;
    rd_word[BIG_M_POS]         = big_m;
    rd_word[BIG_S_POS]         = big_s;
    rd_word[BIG_U_POS]         = big_u;
    rd_word[OVR_POS]           = ovr;
    rd_word[PREV_LO_POS +: 2]  = prev_priv;
  end

  a_r7_machine_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> big_m == $past(wr_word[BIG_M_POS]));

  a_r9_user_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> big_u == (HAS_U ? $past(wr_word[BIG_U_POS]) : 1'b0));

  a_r8_sup_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> big_s == (HAS_S ? $past(wr_word[BIG_S_POS]) : 1'b0));

  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({big_m, big_s, big_u, ovr, prev_priv}));

  a_r10_prev_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    prev_priv != PRIV_RSVD);

endmodule

// File: rtl/endian_priv_resolve.sv
module endian_priv_resolve
  import endian_pkg::*;
(
  input  acc_kind_e kind,
  input  priv_e     cur_priv,
  input  logic      ovr,
  input  priv_e     prev_priv,
  input  logic      big_m,
  input  logic      big_s,
  input  logic      big_u,
  output priv_e     eff_priv,
  output logic      swap_en
);

  logic is_data;
  logic sel_bit;

  assign is_data = (kind != ACC_FETCH);

  always_comb begin
    eff_priv = cur_priv;
    if (is_data && (cur_priv == PRIV_M) && ovr) eff_priv = prev_priv;
  end

  always_comb begin
    unique case (eff_priv)
      PRIV_U:  sel_bit = big_u;
      PRIV_S:  sel_bit = big_s;
      default: sel_bit = big_m;
    endcase
  end

  assign swap_en = is_data && sel_bit;

endmodule

// File: rtl/endian_byte_rev.sv
module endian_byte_rev #(
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned SIZE_W     = 2
) (
  input  logic                    en,
  input  logic [SIZE_W-1:0]       size,
  input  logic [8*DATA_BYTES-1:0] din,
  output logic [8*DATA_BYTES-1:0] dout
);

  localparam int unsigned DATA_W = 8 * DATA_BYTES;
  localparam int unsigned NSIZE  = $clog2(DATA_BYTES) + 1;

  logic [DATA_W-1:0] cand [NSIZE];

  generate
    for (genvar s = 0; s < NSIZE; s++) begin : g_size
      localparam int unsigned NB = 1 << s;
      for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
        if (b < NB) begin : g_rev
          assign cand[s][8*b +: 8] = din[8*(NB-1-b) +: 8];
        end else begin : g_keep
          assign cand[s][8*b +: 8] = din[8*b +: 8];
        end
      end
    end
  endgenerate

  always_comb begin
    dout = din;
    if (en) begin
      dout = cand[NSIZE-1];
      for (int i = 0; i < NSIZE; i++) begin
        if (int'(size) == i) dout = cand[i];
      end
    end
  end

endmodule

// File: rtl/endian_swapper_top.sv
module endian_swapper_top
  import endian_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned STATUS_W   = 64,
  parameter bit          HAS_S      = 1'b1,
  parameter bit          HAS_U      = 1'b1,
  localparam int unsigned DATA_W    = 8 * DATA_BYTES,
  localparam int unsigned SIZE_W    = $clog2($clog2(DATA_BYTES) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_we,
  input  logic [STATUS_W-1:0] csr_wdata,
  output logic [STATUS_W-1:0] csr_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [1:0]          req_priv,
  input  logic [DATA_W-1:0]   req_data,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_swapped
);

  logic  big_m, big_s, big_u, ovr;
  priv_e prev_priv;
  priv_e eff_priv;
  logic  swap_en;

  endian_ctrl_regs #(
    .STATUS_W (STATUS_W),
    .HAS_S    (HAS_S),
    .HAS_U    (HAS_U)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (csr_we),
    .wr_word   (csr_wdata),
    .big_m     (big_m),
    .big_s     (big_s),
    .big_u     (big_u),
    .ovr       (ovr),
    .prev_priv (prev_priv),
    .rd_word   (csr_rdata)
  );

  endian_priv_resolve u_resolve (
    .kind      (acc_kind_e'(req_kind)),
    .cur_priv  (priv_e'(req_priv)),
    .ovr       (ovr),
    .prev_priv (prev_priv),
    .big_m     (big_m),
    .big_s     (big_s),
    .big_u     (big_u),
    .eff_priv  (eff_priv),
    .swap_en   (swap_en)
  );

  endian_byte_rev #(
    .DATA_BYTES (DATA_BYTES),
    .SIZE_W     (SIZE_W)
  ) u_rev (
    .en   (swap_en),
    .size (req_size),
    .din  (req_data),
    .dout (rsp_data)
  );

  // Stream pass-through: no storage, back-pressure flows straight upstream.
  assign rsp_valid   = req_valid;
  assign req_ready   = rsp_ready;
  assign rsp_swapped = swap_en;

  logic unused_eff;
  assign unused_eff = ^eff_priv;

  a_r2_fetch_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |-> (rsp_data == req_data && !rsp_swapped));

  a_r5_single_byte_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == '0) |-> rsp_data == req_data);

  a_r12_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == rsp_ready);

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == req_valid);

  a_r3_unswapped_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_swapped) |-> rsp_data == req_data);

  a_r1_user_without_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd0 && !csr_rdata[BIG_U_POS]) |-> !rsp_swapped);

endmodule

// File: tb/test_endian_swapper_top.sv
module test_endian_swapper_top;

  localparam int unsigned DB = 8;
  localparam int unsigned SW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // Full-featured copy
  logic          we_a = 1'b0;
  logic [SW-1:0] wd_a = '0;
  logic [SW-1:0] rd_a;
  logic          rv_a = 1'b0, rr_a = 1'b1, qr_a, ov_a, sw_a;
  logic [1:0]    kind_a = '0, priv_a = '0;
  logic [1:0]    size_a = '0;
  logic [63:0]   din_a = '0, dout_a;

  // Machine-only copy
  logic          we_b = 1'b0;
  logic [SW-1:0] wd_b = '0;
  logic [SW-1:0] rd_b;
  logic          rv_b = 1'b0, rr_b = 1'b1, qr_b, ov_b, sw_b;
  logic [1:0]    kind_b = '0, priv_b = '0;
  logic [1:0]    size_b = '0;
  logic [63:0]   din_b = '0, dout_b;

  endian_swapper_top #(.DATA_BYTES(DB), .STATUS_W(SW), .HAS_S(1'b1), .HAS_U(1'b1)) i_endian_swapper_top (
    .clk(clk), .rst_n(rst_n), .csr_we(we_a), .csr_wdata(wd_a), .csr_rdata(rd_a),
    .req_valid(rv_a), .req_ready(qr_a), .req_kind(kind_a), .req_size(size_a),
    .req_priv(priv_a), .req_data(din_a), .rsp_valid(ov_a), .rsp_ready(rr_a),
    .rsp_data(dout_a), .rsp_swapped(sw_a));

  endian_swapper_top #(.DATA_BYTES(DB), .STATUS_W(SW), .HAS_S(1'b0), .HAS_U(1'b0)) i_endian_swapper_top_mo (
    .clk(clk), .rst_n(rst_n), .csr_we(we_b), .csr_wdata(wd_b), .csr_rdata(rd_b),
    .req_valid(rv_b), .req_ready(qr_b), .req_kind(kind_b), .req_size(size_b),
    .req_priv(priv_b), .req_data(din_b), .rsp_valid(ov_b), .rsp_ready(rr_b),
    .rsp_data(dout_b), .rsp_swapped(sw_b));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] status_word(bit m, bit s, bit u, bit o, logic [1:0] p);
    logic [63:0] w = '0;
    w[37] = m; w[36] = s; w[6] = u; w[17] = o; w[12:11] = p;
    return w;
  endfunction

  function automatic logic [64:0] model(logic [1:0] kind, logic [1:0] priv, logic [1:0] size,
                                        logic [63:0] d, bit m, bit s, bit u, bit o, logic [1:0] p);
    logic [1:0]  eff = priv;
    bit          sel;
    bit          sw;
    int          n = 1 << size;
    logic [63:0] r = d;
    if (kind != 2'd0 && priv == 2'd3 && o) eff = p;
    sel = (eff == 2'd0) ? u : (eff == 2'd1) ? s : m;
    sw  = (kind != 2'd0) && sel;
    if (sw) for (int b = 0; b < n; b++) r[8*b +: 8] = d[8*(n-1-b) +: 8];
    return {sw, r};
  endfunction

  task automatic write_a(input logic [63:0] w);
    @(negedge clk); we_a = 1'b1; wd_a = w;
    @(negedge clk); we_a = 1'b0; wd_a = ~w;
  endtask

  task automatic write_b(input logic [63:0] w);
    @(negedge clk); we_b = 1'b1; wd_b = w;
    @(negedge clk); we_b = 1'b0; wd_b = ~w;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] prevs [3] = '{2'd0, 2'd1, 2'd3};
    logic [64:0] e;
    repeat (2) @(negedge clk);
    // R6 reset state on both copies
    check("R6 reset fields", rd_a, status_word(0, 0, 0, 0, 2'd3));
    check("R6 reset fields mo", rd_b, status_word(0, 0, 0, 0, 2'd3));
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 still after release", rd_a, status_word(0, 0, 0, 0, 2'd3));

    // R12 stream handshake and back-pressure
    rv_a = 1'b1; rr_a = 1'b0; #1;
    check("R12 ready low under backpressure", {63'd0, qr_a}, 64'd0);
    check("R12 valid follows", {63'd0, ov_a}, 64'd1);
    rr_a = 1'b1; rv_a = 1'b0; #1;
    check("R12 ready follows", {63'd0, qr_a}, 64'd1);
    check("R12 valid low", {63'd0, ov_a}, 64'd0);
    rv_a = 1'b1;

    // R13 read-back masks every other bit
    write_a(64'hFFFF_FFFF_FFFF_FFFF);
    check("R13 readback mask", rd_a, status_word(1, 1, 1, 1, 2'd3));
    // R10 reserved previous-privilege code keeps the old value
    write_a(status_word(0, 0, 0, 0, 2'd1));
    write_a(status_word(0, 0, 0, 0, 2'd2));
    check("R10 reserved prev kept", rd_a, status_word(0, 0, 0, 0, 2'd1));

    // R11 no write: fields hold while wdata toggles
    @(negedge clk); wd_a = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check("R11 hold without write", rd_a, status_word(0, 0, 0, 0, 2'd1));

    // Main sweep: R1 R2 R3 R4 R5 R7 R8 R9 on the full copy
    for (int eb = 0; eb < 8; eb++) begin
      for (int o = 0; o < 2; o++) begin
        for (int pi = 0; pi < 3; pi++) begin
          bit m = eb[2], s = eb[1], u = eb[0];
          write_a(status_word(m, s, u, o[0], prevs[pi]));
          check("R7 R8 R9 R10 write readback", rd_a, status_word(m, s, u, o[0], prevs[pi]));
          for (int pr = 0; pr < 4; pr++) begin
            for (int k = 0; k < 4; k++) begin
              for (int sz = 0; sz < 4; sz++) begin
                logic [7:0] salt = 8'(eb * 37 + pr * 11 + k * 5 + sz);
                logic [63:0] d = 64'h8877_6655_4433_2211 ^ {8{salt}};
                kind_a = 2'(k); priv_a = 2'(pr); size_a = 2'(sz); din_a = d;
                #1;
                e = model(2'(k), 2'(pr), 2'(sz), d, m, s, u, o[0], prevs[pi]);
                if (k == 0)
                  check("R2 fetch data", dout_a, e[63:0]);
                else if (k == 1)
                  check("R3 R1 R5 load data", dout_a, e[63:0]);
                else
                  check("R4 R1 R5 store data", dout_a, e[63:0]);
                check("R1 swap flag", {63'd0, sw_a}, {63'd0, e[64]});
              end
            end
          end
        end
      end
    end

    // Machine-only copy: R8 R9 R10 forced zeros and retained previous field
    rv_b = 1'b1;
    write_b(64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 R9 R10 forced zero mo", rd_b, status_word(1, 0, 0, 0, 2'd3));
    write_b(status_word(1, 1, 1, 1, 2'd0));
    check("R10 unimplemented prev kept mo", rd_b, status_word(1, 0, 0, 0, 2'd3));
    kind_b = 2'd2; priv_b = 2'd0; size_b = 2'd3; din_b = 64'h0102_0304_0506_0708; #1;
    check("R9 user store unswapped mo", dout_b, 64'h0102_0304_0506_0708);
    priv_b = 2'd3; #1;
    check("R7 machine store swapped mo", dout_b, 64'h0807_0605_0403_0201);
    size_b = 2'd1; #1;
    check("R5 two-byte swap upper kept mo", dout_b, 64'h0102_0304_0506_0807);
    // R11 write takes effect on its edge
    @(negedge clk); we_b = 1'b1; wd_b = status_word(0, 0, 0, 0, 2'd3);
    #1;
    check("R11 before edge old value", dout_b, 64'h0102_0304_0506_0807);
    @(negedge clk); we_b = 1'b0; #1;
    check("R11 after edge new value", dout_b, 64'h0102_0304_0506_0708);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule